// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This SIMD datapath block updates a 128-bit accumulator vector from two 128-bit source vectors. All three vectors are split into four independent 32-bit lanes. Each lane holds four bytes. In every lane the block multiplies the four bytes of the first source, read as unsigned values, by the four bytes at the same positions in the second source, read as two's-complement signed values. It adds the four products together, sign-extends the sum and adds it to that lane's accumulator word.

In broadcast mode a 2-bit selector picks one 32-bit group of signed bytes from the second source. That group then serves as the signed operand for all four lanes. The first source and the accumulator still supply their own data in each lane.

Operands are captured on a cycle with `in_valid` high. The updated accumulator appears one clock later with `out_valid`, and the caller writes it back over the old value. The block produces no flags or status.

Top module: `mixdot_acc`

## Requirements
- R1: Each of the four 32-bit lanes is computed in parallel. Lane e of `acc_out` equals lane e of `acc_in` plus the sum of the four byte products of that lane. When lane e of `src_u` is all zero, lane e of `acc_out` equals lane e of `acc_in`.
- R2: Bytes of `src_u` are unsigned (0 to 255), so 0xFF counts as 255.
- R3: Bytes of `src_s` are two's-complement signed (-128 to 127), so 0x80 counts as -128 and 0x7F counts as 127.
- R4: Byte i of lane e occupies bits [32e+8i+7 : 32e+8i]. It multiplies only the byte at the same bit position of the signed operand.
- R5: The accumulator add wraps modulo 2^32, with no saturation and no overflow indication. For example, 0x7FFFFFFF + 129540 gives 0x8001FA03, and 0xFFFFFFFF + 129540 gives 0x0001FA03.
- R6: When `bcast_en` is 1, the signed operand for every lane is bits [32k+31 : 32k] of `src_s`, where k = `bcast_sel` (0 to 3).
- R7: When `bcast_en` is 0, `bcast_sel` has no effect on the result.
- R8: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and `acc_out` then carries that operation's result.
- R9: After a cycle with `in_valid` low, `out_valid` is low and `acc_out` keeps its previous value.
- R10: A synchronous active-high `rst` clears `out_valid` and `acc_out` to zero, and it takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| bcast_en | input | 1 | 1 = broadcast one signed group to all lanes |
| bcast_sel | input | 2 | Index of the broadcast signed group |
| src_u | input | 128 | Unsigned byte source |
| src_s | input | 128 | Signed byte source |
| acc_in | input | 128 | Accumulator lanes before the update |
| out_valid | output | 1 | Result valid |
| acc_out | output | 128 | Updated accumulator lanes |

## Verification
Some behaviours are checked by assertions on every cycle:
- the one-cycle valid timing;
- holding the output when idle;
- a lane with zero unsigned bytes passing its accumulator through;
- lanes with equal inputs producing equal results in broadcast mode.

Other behaviours only the bench scenarios can show. These are the numeric results of the extreme byte products in each position, the wraparound near 0x7FFFFFFF and 0xFFFFFFFF, every broadcast index, and agreement with an independent reference model on random vectors.

// File: rtl/mixdot_acc.sv
module mixdot_acc #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  parameter int BW     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      bcast_en,
  input  logic [$clog2(LANES)-1:0]  bcast_sel,
  input  logic [LANES*LANE_W-1:0]   src_u,
  input  logic [LANES*LANE_W-1:0]   src_s,
  input  logic [LANES*LANE_W-1:0]   acc_in,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   acc_out
);
  localparam int NB = LANE_W / BW;
  localparam int PW = 2 * BW + 1;
  localparam int SW = PW + $clog2(NB);
  localparam int VW = LANES * LANE_W;

  logic [LANE_W-1:0] grp_pick;
  logic [VW-1:0]     acc_nxt;

  assign grp_pick = src_s[bcast_sel*LANE_W +: LANE_W];

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [LANE_W-1:0]   s_op;
    logic signed [SW-1:0] dot;

    assign s_op = bcast_en ? grp_pick : src_s[e*LANE_W +: LANE_W];

    always_comb begin
      logic signed [PW-1:0] ua;
      logic signed [PW-1:0] sb;
      logic signed [PW-1:0] pr;
      dot = '0;
      for (int i = 0; i < NB; i++) begin
        ua  = {{(PW-BW){1'b0}}, src_u[e*LANE_W + i*BW +: BW]};
        sb  = {{(PW-BW){s_op[i*BW+BW-1]}}, s_op[i*BW +: BW]};
        pr  = ua * sb;
        dot = dot + {{(SW-PW){pr[PW-1]}}, pr};
      end
    end

    assign acc_nxt[e*LANE_W +: LANE_W] =
      acc_in[e*LANE_W +: LANE_W] + {{(LANE_W-SW){dot[SW-1]}}, dot};

    AST_ZERO_U_PASS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && src_u[e*LANE_W +: LANE_W] == '0)
      |=> acc_out[e*LANE_W +: LANE_W] == $past(acc_in[e*LANE_W +: LANE_W])); // R1
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) acc_out <= acc_nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc_out)); // R9
  AST_BCAST_SYM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bcast_en
     && src_u[LANE_W-1:0] == src_u[2*LANE_W-1:LANE_W]
     && acc_in[LANE_W-1:0] == acc_in[2*LANE_W-1:LANE_W])
    |=> acc_out[LANE_W-1:0] == acc_out[2*LANE_W-1:LANE_W]); // R6
endmodule

// File: tb/mixdot_acc_tb.sv
module mixdot_acc_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         bcast_en;
  logic [1:0]   bcast_sel;
  logic [127:0] src_u, src_s, acc_in;
  logic         out_valid;
  logic [127:0] acc_out;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mixdot_acc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .bcast_en(bcast_en),
    .bcast_sel(bcast_sel), .src_u(src_u), .src_s(src_s), .acc_in(acc_in),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  localparam logic [127:0] UC = {32'h04040404, 32'h03030303, 32'h02020202, 32'h01010101};
  localparam logic [127:0] SC = {32'h01010101, 32'h02020202, 32'hFFFFFFFF, 32'h80808080};

  // {bcast_en, bcast_sel, src_u, src_s, acc_in, expected}
  localparam logic [514:0] TBL [10] = '{
    {1'b0, 2'd0, {4{32'hFFFFFFFF}}, {4{32'h80808080}}, 128'd0, {4{32'hFFFE0200}}},
    {1'b0, 2'd0, {4{32'hFFFFFFFF}}, {4{32'h7F7F7F7F}},
     {32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h80000000},
     {32'h8001FA03, 32'h0001FA03, 32'h0001FA04, 32'h8001FA04}},
    {1'b0, 2'd0, {32'hFF000000, 32'h00FF0000, 32'h0000FF00, 32'h000000FF},
     {32'h7F7F7F7F, 32'h80808080, 32'h7F7F7F7F, 32'h80808080}, 128'd0,
     {32'h00007E81, 32'hFFFF8080, 32'h00007E81, 32'hFFFF8080}},
    {1'b0, 2'd0, {4{32'h04030201}}, {4{32'hFF010203}}, {4{32'h00000010}}, {4{32'h00000016}}},
    {1'b1, 2'd0, UC, SC, 128'd0, {32'hFFFFF800, 32'hFFFFFA00, 32'hFFFFFC00, 32'hFFFFFE00}},
    {1'b1, 2'd1, UC, SC, 128'd0, {32'hFFFFFFF0, 32'hFFFFFFF4, 32'hFFFFFFF8, 32'hFFFFFFFC}},
    {1'b1, 2'd2, UC, SC, 128'd0, {32'h00000020, 32'h00000018, 32'h00000010, 32'h00000008}},
    {1'b1, 2'd3, UC, SC, 128'd0, {32'h00000010, 32'h0000000C, 32'h00000008, 32'h00000004}},
    {1'b0, 2'd3, UC, SC, 128'd0, {32'h00000010, 32'h00000018, 32'hFFFFFFF8, 32'hFFFFFE00}},
    {1'b0, 2'd1, UC, SC, 128'd0, {32'h00000010, 32'h00000018, 32'hFFFFFFF8, 32'hFFFFFE00}}
  };

  localparam string TREQ [10] = '{"R2 R3", "R5", "R4", "R4", "R6", "R6", "R6", "R6", "R1", "R7"};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_model(input logic m, input logic [1:0] k,
      input logic [127:0] u, input logic [127:0] s, input logic [127:0] a);
    logic [127:0] r;
    for (int e = 0; e < 4; e++) begin
      int sum = 0;
      int lane_s = m ? int'(k) : e;
      for (int i = 0; i < 4; i++) begin
        int ub = int'(u[32*e + 8*i +: 8]);
        int sb = int'($signed(s[32*lane_s + 8*i +: 8]));
        sum += ub * sb;
      end
      r[32*e +: 32] = a[32*e +: 32] + 32'(sum);
    end
    return r;
  endfunction

  task automatic apply(input logic m, input logic [1:0] k,
      input logic [127:0] u, input logic [127:0] s, input logic [127:0] a);
    @(negedge clk);
    in_valid = 1'b1; bcast_en = m; bcast_sel = k;
    src_u = u; src_s = s; acc_in = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; bcast_en = 1'b0; bcast_sel = 2'd0;
    src_u = '0; src_s = '0; acc_in = '0;
    repeat (2) @(negedge clk);
    chk("R10 reset valid", {127'd0, out_valid}, 128'd0);
    chk("R10 reset data", acc_out, 128'd0);
    rst = 1'b0;

    for (int n = 0; n < 10; n++) begin
      apply(TBL[n][514], TBL[n][513:512], TBL[n][511:384], TBL[n][383:256], TBL[n][255:128]);
      chk({TREQ[n], " valid"}, {127'd0, out_valid}, 128'd1);
      chk(TREQ[n], acc_out, TBL[n][127:0]);
    end

    // R8 / R9: a cycle after an idle cycle drops valid and holds the data
    @(negedge clk);
    src_u = {4{32'hFFFFFFFF}}; src_s = {4{32'h7F7F7F7F}};
    chk("R9 valid low", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    chk("R9 hold", acc_out, TBL[9][127:0]);

    // R1: a zero unsigned lane passes the accumulator through
    apply(1'b0, 2'd0, {32'hFFFFFFFF, 32'd0, 32'hFFFFFFFF, 32'd0}, {4{32'h80808080}},
          {32'h00000001, 32'h12345678, 32'h00000002, 32'h9ABCDEF0});
    chk("R1", acc_out, {32'hFFFE0201, 32'h12345678, 32'hFFFE0202, 32'h9ABCDEF0});

    // back-to-back inputs
    @(negedge clk);
    in_valid = 1'b1; bcast_en = 1'b0; src_u = {4{32'h01010101}};
    src_s = {4{32'h02020202}}; acc_in = '0;
    @(negedge clk);
    chk("R8 b2b first", acc_out, {4{32'h00000008}});
    acc_in = {4{32'h00000008}};
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 b2b second", acc_out, {4{32'h00000010}});

    // R10: reset wins over in_valid
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    chk("R10 reset priority", {out_valid, acc_out[126:0]}, 128'd0);

    // random vectors against the reference model
    for (int n = 0; n < 200; n++) begin
      logic [127:0] u, s, a;
      logic m;
      logic [1:0] k;
      u = {$urandom, $urandom, $urandom, $urandom};
      s = {$urandom, $urandom, $urandom, $urandom};
      a = {$urandom, $urandom, $urandom, $urandom};
      m = 1'($urandom);
      k = 2'($urandom);
      apply(m, k, u, s, a);
      chk("R1 R6 random", acc_out, ref_model(m, k, u, s, a));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule